// File: doc/BRIEF.md
# Boot-Overlay System Address Decoder

This block turns a 24-bit processor address into one active-low select for each memory or peripheral device on the bus: RAM, ROM, a SCSI controller, a serial controller, a floppy controller and a parallel I/O peripheral. It also raises an autovector request for the interrupt acknowledge area at the very top of the map, and a bus-error request for every address that maps to nothing. The whole decode is combinational from the address, the strobes and one stored bit, so each select follows the address in the same cycle.

The stored bit is a boot overlay flag. Reset sets it. While it is set, the bottom 4 MB zone shows ROM, so the processor can fetch its reset vectors there, and RAM is reachable through a 1 MB alias in the second zone. A one-cycle pulse on the overlay-clear input drops the flag for good. RAM then appears at address zero, and the alias becomes a hole.

Two straps give the RAM size. One strap picks the bank size: 512 KB with small modules or 2 MB with large ones. The other says whether a second bank is fitted. RAM addresses beyond the fitted size return a bus error instead of a select.

Top module: `sysdec_top`

## Requirements
- R1: Reset sets the overlay flag. While the flag is set, any access to 0x000000–0x3FFFFF asserts only `romSelN`.
- R2: `ovlClr` high at a rising clock edge clears the overlay flag from the next cycle on. Later pulses on `ovlClr` change nothing. Only reset sets the flag again. With the flag clear, 0x000000–0x3FFFFF decodes as RAM and is subject to R9.
- R3: 0x400000–0x4FFFFF asserts `romSelN` whatever the overlay state.
- R4: 0x580000–0x5FFFFF asserts `scsiSelN`.
- R5: While the flag is set, 0x600000–0x6FFFFF asserts `ramSelN`. The RAM offset is the address minus 0x600000, and R9 applies to it. While the flag is clear, the same window asserts `berrReq`.
- R6: 0x800000–0xBFFFFF asserts `sccSelN`. `sccRdN` is also asserted, but only in the read half 0x800000–0x9FFFFF.
- R7: 0xC00000–0xDFFFFF asserts `floppySelN`. 0xE80000–0xEFFFFF asserts `pioSelN`.
- R8: 0xFFFFF0–0xFFFFFF asserts `avecReq` with no select and no bus error.
- R9: The RAM size limit is the bank size times the number of banks. The bank size is 512 KB when `bigSimm`=0 and 2 MB when `bigSimm`=1. The bank count is 2 when `bankTwo`=1 and 1 otherwise. A RAM offset at or above the limit asserts `berrReq` instead of `ramSelN`.
- R10: The holes 0x500000–0x57FFFF, 0x700000–0x7FFFFF, 0xE00000–0xE7FFFF and 0xF00000–0xFFFFEF assert `berrReq` and no select.
- R11: No select, no `sccRdN`, no `berrReq` and no `avecReq` is asserted unless `asN` is low and at least one of `udsN`/`ldsN` is low.
- R12: At most one of the six selects is active. `berrReq` and `avecReq` are never active together with a select or with each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the overlay flag |
| rstN | input | 1 | Asynchronous active-low reset; sets the overlay flag |
| addr | input | 24 | Processor byte address |
| asN | input | 1 | Address strobe, active low |
| udsN | input | 1 | Upper data strobe, active low |
| ldsN | input | 1 | Lower data strobe, active low |
| ovlClr | input | 1 | Overlay clear pulse, active high |
| bankTwo | input | 1 | Strap: second RAM bank fitted |
| bigSimm | input | 1 | Strap: 2 MB banks (1) or 512 KB banks (0) |
| ramSelN | output | 1 | RAM select, active low |
| romSelN | output | 1 | ROM select, active low |
| scsiSelN | output | 1 | SCSI controller select, active low |
| sccSelN | output | 1 | Serial controller select, active low |
| sccRdN | output | 1 | Serial controller read strobe, active low |
| floppySelN | output | 1 | Floppy controller select, active low |
| pioSelN | output | 1 | Parallel I/O peripheral select, active low |
| berrReq | output | 1 | Bus-error request, active high |
| avecReq | output | 1 | Autovector request, active high |

## Verification
The hardest case to reach is the interaction between the overlay state and the RAM size straps. Whether the high alias, or zone zero, selects RAM or flags a bus error depends on the stored flag and on both straps together. The flag can only go from set to clear once per reset.

The stimulus therefore sweeps every region edge and the address just below it under all four strap settings. It does this once with the overlay set, then issues the clear pulse and repeats the sweep. Random addresses and strobes fill in between. A second clear pulse and a second reset finish the run, which shows that only reset restores the overlay.

// File: rtl/sysdec_pkg.sv
package sysdec_pkg;

  localparam int SEL_COUNT  = 6;
  localparam int SEL_RAM    = 0;
  localparam int SEL_ROM    = 1;
  localparam int SEL_SCSI   = 2;
  localparam int SEL_SCC    = 3;
  localparam int SEL_FLOPPY = 4;
  localparam int SEL_PIO    = 5;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_RAM,
    RG_ROM,
    RG_SCSI,
    RG_SCC_RD,
    RG_SCC_WR,
    RG_FLOPPY,
    RG_PIO,
    RG_AVEC
  } region_e;

  // Strobes from the control side to the decode datapath.
  typedef struct packed {
    logic overlayOn;
    logic cycleActive;
    logic bankTwo;
    logic bigSimm;
  } ctrlStrobes_t;

endpackage

// File: rtl/sysdec_ctrl.sv
module sysdec_ctrl
  import sysdec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         asN,
  input  logic         udsN,
  input  logic         ldsN,
  input  logic         ovlClr,
  input  logic         bankTwo,
  input  logic         bigSimm,
  output ctrlStrobes_t strobes
);

  logic overlayQ;

  // Set by reset, cleared once by a pulse, never set again until reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       overlayQ <= 1'b1;
    else if (ovlClr) overlayQ <= 1'b0;
  end

  always_comb begin
    strobes.overlayOn   = overlayQ;
    strobes.cycleActive = !asN && (!udsN || !ldsN);
    strobes.bankTwo     = bankTwo;
    strobes.bigSimm     = bigSimm;
  end

  // R2: a clear pulse takes effect on the next cycle
  a_r2_clear_applies: assert property (@(posedge clk) disable iff (!rstN)
    ovlClr |=> !overlayQ);

  // R2: once cleared the flag stays cleared until reset
  a_r2_stays_clear: assert property (@(posedge clk) disable iff (!rstN)
    !overlayQ |=> !overlayQ);

endmodule

// File: rtl/sysdec_path.sv
module sysdec_path
  import sysdec_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int SMALL_BANK_LOG2 = 19,
  parameter int BIG_BANK_LOG2   = 21
) (
  input  logic [ADDR_W-1:0]    addr,
  input  ctrlStrobes_t         strobes,
  output logic [SEL_COUNT-1:0] selVec,
  output logic                 sccRd,
  output logic                 berr,
  output logic                 avec
);

  localparam int HI_W    = 8;
  localparam int HI_LSB  = ADDR_W - HI_W;
  localparam int ZONE0_W = ADDR_W - 2;
  localparam int ALIAS_W = ADDR_W - 4;
  localparam logic [ZONE0_W:0] SMALL_LIM = (ZONE0_W+1)'(1) << SMALL_BANK_LOG2;
  localparam logic [ZONE0_W:0] BIG_LIM   = (ZONE0_W+1)'(1) << BIG_BANK_LOG2;

  logic [HI_W-1:0]    hi;
  logic               lowOnes;
  region_e            region;
  logic [ZONE0_W-1:0] ramOff;
  logic [ZONE0_W:0]   ramLimit;
  logic               ramFits;

  assign hi      = addr[ADDR_W-1 -: HI_W];
  assign lowOnes = &addr[HI_LSB-1:4];

  // Region decode: the top two bits give the zone, the next bits pick the window.
  always_comb begin
    region = RG_NONE;
    ramOff = '0;
    unique case (hi[7:6])
      2'd0: begin
        if (strobes.overlayOn) begin
          region = RG_ROM;
        end else begin
          region = RG_RAM;
          ramOff = addr[ZONE0_W-1:0];
        end
      end
      2'd1: begin
        if (hi[5:4] == 2'b00) begin
          region = RG_ROM;
        end else if (hi[5:3] == 3'b011) begin
          region = RG_SCSI;
        end else if (hi[5:4] == 2'b10 && strobes.overlayOn) begin
          region = RG_RAM;
          ramOff = ZONE0_W'(addr[ALIAS_W-1:0]);
        end
      end
      2'd2: region = hi[5] ? RG_SCC_WR : RG_SCC_RD;
      2'd3: begin
        if (!hi[5]) begin
          region = RG_FLOPPY;
        end else if (hi[5:3] == 3'b101) begin
          region = RG_PIO;
        end else if (hi == 8'hFF && lowOnes) begin
          region = RG_AVEC;
        end
      end
      default: region = RG_NONE;
    endcase
  end

  // Installed RAM size from the straps.
  always_comb begin
    ramLimit = (strobes.bigSimm ? BIG_LIM : SMALL_LIM) << strobes.bankTwo;
    ramFits  = {1'b0, ramOff} < ramLimit;
  end

  // Output stage, gated by an active bus cycle.
  always_comb begin
    selVec = '0;
    sccRd  = 1'b0;
    berr   = 1'b0;
    avec   = 1'b0;
    if (strobes.cycleActive) begin
      unique case (region)
        RG_RAM: begin
          if (ramFits) selVec[SEL_RAM] = 1'b1;
          else         berr            = 1'b1;
        end
        RG_ROM:    selVec[SEL_ROM]    = 1'b1;
        RG_SCSI:   selVec[SEL_SCSI]   = 1'b1;
        RG_SCC_RD: begin
          selVec[SEL_SCC] = 1'b1;
          sccRd           = 1'b1;
        end
        RG_SCC_WR: selVec[SEL_SCC]    = 1'b1;
        RG_FLOPPY: selVec[SEL_FLOPPY] = 1'b1;
        RG_PIO:    selVec[SEL_PIO]    = 1'b1;
        RG_AVEC:   avec               = 1'b1;
        default:   berr               = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/sysdec_top.sv
module sysdec_top
  import sysdec_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int SMALL_BANK_LOG2 = 19,
  parameter int BIG_BANK_LOG2   = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              asN,
  input  logic              udsN,
  input  logic              ldsN,
  input  logic              ovlClr,
  input  logic              bankTwo,
  input  logic              bigSimm,
  output logic              ramSelN,
  output logic              romSelN,
  output logic              scsiSelN,
  output logic              sccSelN,
  output logic              sccRdN,
  output logic              floppySelN,
  output logic              pioSelN,
  output logic              berrReq,
  output logic              avecReq
);

  ctrlStrobes_t         strobes;
  logic [SEL_COUNT-1:0] selVec;
  logic [SEL_COUNT-1:0] selN;
  logic                 sccRd;

  sysdec_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .asN     (asN),
    .udsN    (udsN),
    .ldsN    (ldsN),
    .ovlClr  (ovlClr),
    .bankTwo (bankTwo),
    .bigSimm (bigSimm),
    .strobes (strobes)
  );

  sysdec_path #(
    .ADDR_W          (ADDR_W),
    .SMALL_BANK_LOG2 (SMALL_BANK_LOG2),
    .BIG_BANK_LOG2   (BIG_BANK_LOG2)
  ) u_path (
    .addr    (addr),
    .strobes (strobes),
    .selVec  (selVec),
    .sccRd   (sccRd),
    .berr    (berrReq),
    .avec    (avecReq)
  );

  for (genvar i = 0; i < SEL_COUNT; i++) begin : g_selInv
    assign selN[i] = ~selVec[i];
  end

  assign ramSelN    = selN[SEL_RAM];
  assign romSelN    = selN[SEL_ROM];
  assign scsiSelN   = selN[SEL_SCSI];
  assign sccSelN    = selN[SEL_SCC];
  assign floppySelN = selN[SEL_FLOPPY];
  assign pioSelN    = selN[SEL_PIO];
  assign sccRdN     = ~sccRd;

  // R1: overlay maps zone zero to ROM
  a_r1_overlay_rom: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.overlayOn && strobes.cycleActive && addr[ADDR_W-1 -: 2] == 2'd0) |-> !romSelN);

  // R5: the high RAM alias is a hole once the overlay is gone
  a_r5_alias_gone: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.overlayOn && strobes.cycleActive && addr[ADDR_W-1 -: 4] == 4'h6) |-> berrReq);

  // R6: the read strobe only comes with the serial select
  a_r6_rd_with_sel: assert property (@(posedge clk) disable iff (!rstN)
    !sccRdN |-> !sccSelN);

  // R8: autovector only for the top sixteen bytes
  a_r8_avec_top: assert property (@(posedge clk) disable iff (!rstN)
    avecReq |-> (&addr[ADDR_W-1:4]));

  // R11: nothing is driven outside a bus cycle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    asN |-> ((&selN) && sccRdN && !berrReq && !avecReq));

  // R12: selects are mutually exclusive
  a_r12_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selVec));

  // R12: bus error and autovector stand alone
  a_r12_berr_alone: assert property (@(posedge clk) disable iff (!rstN)
    berrReq |-> ((&selN) && !avecReq));

endmodule

// File: tb/sim_sysdec_top.sv
`timescale 1ns/1ps
module sim_sysdec_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [23:0] addr;
  logic        asN, udsN, ldsN, ovlClr, bankTwo, bigSimm;
  logic        ramSelN, romSelN, scsiSelN, sccSelN, sccRdN;
  logic        floppySelN, pioSelN, berrReq, avecReq;

  int  checks = 0;
  int  fails  = 0;
  bit  ovlModel;
  bit  finished = 1'b0;
  int unsigned seedVal;

  always #2 clk = ~clk;

  sysdec_top u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .asN(asN), .udsN(udsN), .ldsN(ldsN),
    .ovlClr(ovlClr), .bankTwo(bankTwo), .bigSimm(bigSimm),
    .ramSelN(ramSelN), .romSelN(romSelN), .scsiSelN(scsiSelN), .sccSelN(sccSelN),
    .sccRdN(sccRdN), .floppySelN(floppySelN), .pioSelN(pioSelN),
    .berrReq(berrReq), .avecReq(avecReq)
  );

  // Expected {avec, berr, sccRd, pio, floppy, scc, scsi, rom, ram}, active high.
  function automatic logic [8:0] refDecode(int a, bit ovl, bit two, bit big, bit act);
    int lim;
    logic [8:0] e;
    lim = (big ? 2097152 : 524288) * (two ? 2 : 1);
    e = '0;
    if (!act) return e;
    if (a < 'h400000) begin
      if (ovl)          e[1] = 1'b1;
      else if (a < lim) e[0] = 1'b1;
      else              e[7] = 1'b1;
    end
    else if (a < 'h500000) e[1] = 1'b1;
    else if (a < 'h580000) e[7] = 1'b1;
    else if (a < 'h600000) e[2] = 1'b1;
    else if (a < 'h700000) begin
      if (ovl && (a - 'h600000) < lim) e[0] = 1'b1;
      else                             e[7] = 1'b1;
    end
    else if (a < 'h800000) e[7] = 1'b1;
    else if (a < 'hA00000) begin e[3] = 1'b1; e[6] = 1'b1; end
    else if (a < 'hC00000) e[3] = 1'b1;
    else if (a < 'hE00000) e[4] = 1'b1;
    else if (a < 'hE80000) e[7] = 1'b1;
    else if (a < 'hF00000) e[5] = 1'b1;
    else if (a < 'hFFFFF0) e[7] = 1'b1;
    else                   e[8] = 1'b1;
    return e;
  endfunction

  function automatic string tagFor(int a);
    if (a < 'h400000) return "R1/R2/R9";
    if (a < 'h500000) return "R3";
    if (a < 'h580000) return "R10";
    if (a < 'h600000) return "R4";
    if (a < 'h700000) return "R5/R9";
    if (a < 'h800000) return "R10";
    if (a < 'hC00000) return "R6";
    if (a < 'hE00000) return "R7";
    if (a < 'hE80000) return "R10";
    if (a < 'hF00000) return "R7";
    if (a < 'hFFFFF0) return "R10";
    return "R8";
  endfunction

  function automatic int bnd(int i);
    case (i)
      0: return 'h000000;  1: return 'h080000;  2: return 'h100000;
      3: return 'h200000;  4: return 'h400000;  5: return 'h500000;
      6: return 'h580000;  7: return 'h600000;  8: return 'h680000;
      9: return 'h700000; 10: return 'h800000; 11: return 'hA00000;
     12: return 'hC00000; 13: return 'hE00000; 14: return 'hE80000;
     15: return 'hF00000; 16: return 'hFFFFF0; default: return 'hFFFFFF;
    endcase
  endfunction

  task automatic probe(input int a, input bit as_, input bit uds_, input bit lds_, input string tag);
    logic [8:0] exp, got;
    @(negedge clk);
    addr = a[23:0]; asN = as_; udsN = uds_; ldsN = lds_;
    #1;
    exp = refDecode(a & 'hFFFFFF, ovlModel, bankTwo, bigSimm, !as_ && (!uds_ || !lds_));
    got = {avecReq, berrReq, !sccRdN, !pioSelN, !floppySelN, !sccSelN, !scsiSelN, !romSelN, !ramSelN};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h ovl=%0d straps=%0d%0d actual=%b expected=%b",
               tag, a[23:0], ovlModel, bankTwo, bigSimm, got, exp);
    end
  endtask

  task automatic sweep();
    for (int s = 0; s < 4; s++) begin
      bankTwo = s[1]; bigSimm = s[0];
      for (int i = 0; i < 18; i++) begin
        int b;
        b = bnd(i);
        probe(b, 1'b0, 1'b0, 1'b0, {tagFor(b), " R12"});
        if (b > 0) probe(b - 1, 1'b0, 1'b1, 1'b0, {tagFor(b - 1), " R12"});
      end
    end
  endtask

  task automatic randomRun(input int n);
    for (int k = 0; k < n; k++) begin
      int  a;
      bit  as_, uds_, lds_;
      a = int'($urandom() & 32'hFFFFFF);
      as_  = ($urandom() % 5) == 0;
      uds_ = $urandom() % 2;
      lds_ = $urandom() % 2;
      bankTwo = $urandom() % 2;
      bigSimm = $urandom() % 2;
      probe(a, as_, uds_, lds_, (as_ || (uds_ && lds_)) ? "R11" : tagFor(a));
    end
  endtask

  task automatic pulseClear();
    @(negedge clk); ovlClr = 1'b1;
    @(negedge clk); ovlClr = 1'b0;
    ovlModel = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    ovlModel = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    seedVal = $urandom(32'd2718);
    rstN = 1'b0; addr = '0; asN = 1'b1; udsN = 1'b1; ldsN = 1'b1;
    ovlClr = 1'b0; bankTwo = 1'b0; bigSimm = 1'b0; ovlModel = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state: overlay set, ROM at zero (R1); idle bus is quiet (R11)
    probe('h000000, 1'b1, 1'b0, 1'b0, "R11");
    probe('h000000, 1'b0, 1'b0, 1'b1, "R1");
    probe('h123456, 1'b0, 1'b1, 1'b1, "R11");

    sweep();
    randomRun(600);

    // A clear pulse held across reset must not survive it (R2)
    @(negedge clk); ovlClr = 1'b1; rstN = 1'b0;
    @(negedge clk); ovlClr = 1'b0; rstN = 1'b1;
    probe('h000100, 1'b0, 1'b0, 1'b0, "R1");

    pulseClear();
    bankTwo = 1'b1; bigSimm = 1'b1;
    probe('h000100, 1'b0, 1'b0, 1'b0, "R2");
    probe('h600100, 1'b0, 1'b0, 1'b0, "R5");

    sweep();
    randomRun(600);

    // Further pulses leave the overlay cleared (R2)
    pulseClear();
    bankTwo = 1'b0; bigSimm = 1'b0;
    probe('h07FFFE, 1'b0, 1'b0, 1'b0, "R2");
    probe('h080000, 1'b0, 1'b0, 1'b0, "R9");

    // Only reset brings the overlay back (R1)
    doReset();
    probe('h07FFFE, 1'b0, 1'b0, 1'b0, "R1");
    probe('h67FFFE, 1'b0, 1'b0, 1'b0, "R5");
    probe('h680000, 1'b0, 1'b0, 1'b0, "R9");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule